// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a system watchdog seen by software as four 32-bit registers on a single-cycle register bus. A 16-bit up-counter advances once per prescaled tick while counting is enabled. When it wraps from 0xFFFF to 0x0000, the block latches a sticky overflow flag. It then raises a level interrupt if the interrupt enable is set, and fires a one-cycle reset request unless the reset mask is set. A timeout of N ticks is programmed by loading 0x10000 minus N.

Every register write carries a fixed key in its upper bits. A write whose key does not match changes nothing. An accepted write to the counter or to the main control register starts a short write-in-progress window. The busy flag shows that window, and software polls it before setting the enable bit.

The bus has no stream data path, so there is no valid/ready handshake. A write is one cycle with `bus_wen` high. A read is combinational from `bus_addr`. The interrupt and reset outputs are plain level and pulse pins.

Top module: `key_wdt`

## Requirements
- R1: After reset the counter reads 0x0000F488, the other three registers read 0, and both the interrupt and the reset request are low.
- R2: A write to index 0 loads bits 15:0 into the counter only when bits 31:16 equal 0x5A5A. A load wins over a same-cycle count step. Any other upper value leaves the counter unchanged.
- R3: A write to index 1 is accepted only when bits 31:8 equal 0xA5A5A5. The fields are:
  - bit 7: count enable
  - bit 3: interrupt enable
  - bits 2:0: clock select
  - bit 4: overflow flag. Writing 0 clears it; writing 1 has no effect.
  - bit 5: busy flag, read-only.
- R4: A write to index 2 stores bits 5:0 as the external divide select, only when bits 31:8 equal 0xA5A5A5.
- R5: A write to index 3 stores bits 15:0 only when bits 31:16 equal 0xA55A. Bit 1 of this register masks the reset request.
- R6: Clock select values 0 to 6 give one tick every 2^(sel+2) clock cycles, so value 2 divides by 16. Value 7 gives one tick every (external select + 1) cycles.
- R7: While enabled, the counter rises by exactly one per tick. While disabled, it holds its value.
- R8: On a wrap from 0xFFFF to 0 while enabled, the overflow flag is set and stays set until cleared. The interrupt output is high exactly while the flag and the interrupt enable are both 1.
- R9: The reset request is high for one cycle, at the edge after the wrap, and only if the mask bit is 0.
- R10: An accepted write to index 0 or index 1 sets the busy flag and restarts the prescaler. The flag clears after 2 ticks, which is 2×divisor cycles. Writes with a wrong key, and writes to index 2 or 3, do not set it.
- R11: Reads return the stored fields with all key bits and unused bits reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register index: 0 counter, 1 control, 2 divide select, 3 reset control |
| bus_wdata | input | 32 | Write data including key bits |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wdt_irq | output | 1 | Overflow interrupt, level |
| wdt_rst_req | output | 1 | Reset request, one-cycle pulse |

## Verification
A corrupted counter or prescaler state shows up as a wrong count readback within one tick. It also shows up as a reset pulse or interrupt at a cycle other than the one predicted from the loaded value. Stale busy state is visible on bit 5 of the control readback, one cycle after the write and again at exactly 2×divisor cycles. A key decoder that accepts a bad key is caught on the very next read of the targeted register, because the stored field would differ.

// File: rtl/key_wdt_pkg.sv
`timescale 1ns/1ps
package key_wdt_pkg;
  localparam int CNT_W        = 16;
  localparam int RSTC_W       = 16;
  localparam int RST_MASK_BIT = 1;

  localparam logic [15:0] KEY_CNT  = 16'h5A5A;
  localparam logic [23:0] KEY_CTL  = 24'hA5A5A5;
  localparam logic [15:0] KEY_RSTC = 16'hA55A;

  localparam int BIT_RUN  = 7;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OVF  = 4;
  localparam int BIT_IE   = 3;

  localparam logic [2:0] SEL_EXT = 3'd7;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_CTLA = 2'd1,
    REG_CTLB = 2'd2,
    REG_RSTC = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic       run;
    logic       ovf_ie;
    logic [2:0] clk_sel;
  } ctla_t;
endpackage

// File: rtl/wdt_keyed_regs.sv
`timescale 1ns/1ps
module wdt_keyed_regs
  import key_wdt_pkg::*;
#(
  parameter int SELB_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              busy,
  input  logic              ovf_evt,
  output logic              run,
  output logic              ovf_ie,
  output logic [2:0]        clk_sel,
  output logic [SELB_W-1:0] selb,
  output logic              rst_mask,
  output logic              ovf_flag,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              restart,
  output logic [31:0]       rdata
);
  reg_idx_e          sel;
  logic              key_cnt_ok, key_ctl_ok, key_rst_ok;
  logic              wr_cnt, wr_cta, wr_ctb, wr_rst;
  ctla_t             ctla_q;
  logic              ovf_q;
  logic [SELB_W-1:0] selb_q;
  logic [RSTC_W-1:0] rstc_q;
  logic [7:0]        ctla_rd;
  logic              unused_wbit6;

  assign sel        = reg_idx_e'(addr);
  assign key_cnt_ok = (wdata[31:16] == KEY_CNT);
  assign key_ctl_ok = (wdata[31:8]  == KEY_CTL);
  assign key_rst_ok = (wdata[31:16] == KEY_RSTC);

  // Keyed write decode (R2..R5)
  assign wr_cnt = wen && (sel == REG_CNT)  && key_cnt_ok;
  assign wr_cta = wen && (sel == REG_CTLA) && key_ctl_ok;
  assign wr_ctb = wen && (sel == REG_CTLB) && key_ctl_ok;
  assign wr_rst = wen && (sel == REG_RSTC) && key_rst_ok;

  assign unused_wbit6 = wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q <= '0;
    end else if (wr_cta) begin
      ctla_q.run     <= wdata[BIT_RUN];
      ctla_q.ovf_ie  <= wdata[BIT_IE];
      ctla_q.clk_sel <= wdata[2:0];
    end
  end

  // Sticky overflow: a new event wins over a clearing write (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (ovf_evt) begin
      ovf_q <= 1'b1;
    end else if (wr_cta && !wdata[BIT_OVF]) begin
      ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selb_q <= '0;
    end else if (wr_ctb) begin
      selb_q <= wdata[SELB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstc_q <= '0;
    end else if (wr_rst) begin
      rstc_q <= wdata[RSTC_W-1:0];
    end
  end

  always_comb begin
    ctla_rd           = '0;
    ctla_rd[BIT_RUN]  = ctla_q.run;
    ctla_rd[BIT_BUSY] = busy;
    ctla_rd[BIT_OVF]  = ovf_q;
    ctla_rd[BIT_IE]   = ctla_q.ovf_ie;
    ctla_rd[2:0]      = ctla_q.clk_sel;
  end

  // Read mux: key bits read as zero (R11)
  always_comb begin
    unique case (sel)
      REG_CNT:  rdata = 32'(cnt_val);
      REG_CTLA: rdata = 32'(ctla_rd);
      REG_CTLB: rdata = 32'(selb_q);
      REG_RSTC: rdata = 32'(rstc_q);
      default:  rdata = '0;
    endcase
  end

  assign run          = ctla_q.run;
  assign ovf_ie       = ctla_q.ovf_ie;
  assign clk_sel      = ctla_q.clk_sel;
  assign selb         = selb_q;
  assign rst_mask     = rstc_q[RST_MASK_BIT];
  assign ovf_flag     = ovf_q;
  assign cnt_load     = wr_cnt;
  assign cnt_load_val = wdata[CNT_W-1:0];
  assign restart      = wr_cnt || wr_cta;
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler
  import key_wdt_pkg::*;
#(
  parameter int SELB_W = 6,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        clk_sel,
  input  logic [SELB_W-1:0] selb,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   div_m1;
  logic             at_end;

  // Divisor minus one (R6)
  always_comb begin
    if (clk_sel == SEL_EXT) begin
      div_m1 = (PRE_W+1)'(selb);
    end else begin
      div_m1 = ((PRE_W+1)'(4) << clk_sel) - (PRE_W+1)'(1);
    end
  end

  // ">=" keeps the phase bounded when the divisor shrinks mid-period
  assign at_end = ({1'b0, pre_q} >= div_m1);
  assign tick   = at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || at_end) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_busy_track.sv
`timescale 1ns/1ps
module wdt_busy_track #(
  parameter int BUSY_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic busy
);
  localparam int BW = $clog2(BUSY_TICKS + 1);

  logic [BW-1:0] left_q;

  // Write-in-progress window (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (arm) begin
      left_q <= BW'(BUSY_TICKS);
    end else if (tick && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/wdt_upcounter.sv
`timescale 1ns/1ps
module wdt_upcounter
  import key_wdt_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_COUNT = 16'hF488
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q;

  // R2: load has priority; R7: step per tick while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_COUNT;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ovf_evt = run && tick && !load && (cnt_q == '1);
  assign count   = cnt_q;
endmodule

// File: rtl/key_wdt.sv
`timescale 1ns/1ps
module key_wdt
  import key_wdt_pkg::*;
#(
  parameter logic [15:0] RESET_COUNT = 16'hF488,
  parameter int          SELB_W      = 6,
  parameter int          BUSY_TICKS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_rst_req
);
  localparam int FIX_DIV_MAX = 4 << 6;
  localparam int EXT_DIV_MAX = 1 << SELB_W;
  localparam int DIV_MAX     = (FIX_DIV_MAX > EXT_DIV_MAX) ? FIX_DIV_MAX : EXT_DIV_MAX;
  localparam int PRE_W       = $clog2(DIV_MAX);

  logic              run_en, ovf_ie, rst_mask, ovf_flag;
  logic [2:0]        clk_sel;
  logic [SELB_W-1:0] selb;
  logic              cnt_load, restart, tick, busy_flag, ovf_evt;
  logic [CNT_W-1:0]  cnt_load_val, cnt_val;

  wdt_keyed_regs #(.SELB_W(SELB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_val(cnt_val), .busy(busy_flag), .ovf_evt(ovf_evt),
    .run(run_en), .ovf_ie(ovf_ie), .clk_sel(clk_sel), .selb(selb),
    .rst_mask(rst_mask), .ovf_flag(ovf_flag), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .restart(restart), .rdata(bus_rdata)
  );

  wdt_prescaler #(.SELB_W(SELB_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .clk_sel(clk_sel),
    .selb(selb), .tick(tick)
  );

  wdt_busy_track #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .arm(restart), .tick(tick), .busy(busy_flag)
  );

  wdt_upcounter #(.RESET_COUNT(RESET_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .run(run_en), .tick(tick), .count(cnt_val), .ovf_evt(ovf_evt)
  );

  // R9: registered one-cycle reset request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_rst_req <= 1'b0;
    end else begin
      wdt_rst_req <= ovf_evt && !rst_mask;
    end
  end

  // R8: interrupt follows flag and enable
  assign wdt_irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import key_wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wen,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [CNT_W-1:0] cnt_val,
  input logic             busy_flag,
  input logic             rst_mask,
  input logic             ovf_flag,
  input logic             run_en,
  input logic             wdt_rst_req
);
  logic cnt_wr_ok, cta_wr_ok, cta_clear, rst_wr_bad;

  assign cnt_wr_ok  = bus_wen && bus_addr == 2'd0 && bus_wdata[31:16] == KEY_CNT;
  assign cta_wr_ok  = bus_wen && bus_addr == 2'd1 && bus_wdata[31:8] == KEY_CTL;
  assign cta_clear  = cta_wr_ok && !bus_wdata[BIT_OVF];
  assign rst_wr_bad = bus_wen && bus_addr == 2'd3 && bus_wdata[31:16] != KEY_RSTC;

  p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_ok |=> (cnt_val == $past(bus_wdata[15:0])));

  p_rstc_badkey_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr_bad |=> $stable(rst_mask));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr_ok) |=> $stable(cnt_val));

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_ok |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 16'd1));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cta_clear) |=> ovf_flag);

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  p_rst_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> !$past(rst_mask));

  p_busy_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_ok || cta_wr_ok) |=> busy_flag);
endmodule

bind key_wdt wdt_checker u_wdt_chk (
  .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_val(cnt_val), .busy_flag(busy_flag),
  .rst_mask(rst_mask), .ovf_flag(ovf_flag), .run_en(run_en),
  .wdt_rst_req(wdt_rst_req)
);

// File: tb/key_wdt_bench.sv
`timescale 1ns/1ps
module key_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_irq;
  logic        wdt_rst_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  key_wdt u_key_wdt (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq),
    .wdt_rst_req(wdt_rst_req)
  );

  // {index, write data, expected readback right after the write}
  localparam logic [65:0] VECS [0:10] = '{
    {2'd0, 32'h5A5A_1234, 32'h0000_1234},
    {2'd0, 32'h5A5B_7777, 32'h0000_1234},
    {2'd0, 32'h0000_FFFF, 32'h0000_1234},
    {2'd2, 32'hA5A5_A53F, 32'h0000_003F},
    {2'd2, 32'hA5A5_A401, 32'h0000_003F},
    {2'd2, 32'hA5A5_A5C5, 32'h0000_0005},
    {2'd3, 32'hA55A_00F2, 32'h0000_00F2},
    {2'd3, 32'h5AA5_0000, 32'h0000_00F2},
    {2'd1, 32'hA5A5_A52B, 32'h0000_002B},
    {2'd1, 32'hA5A5_A60C, 32'h0000_000B},
    {2'd1, 32'hA5A5_A507, 32'h0000_0027}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wen   = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wen   = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    bus_wen   = 1'b0;
    bus_addr  = 2'd0;
    bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk_rd("R1 count", 2'd0, 32'h0000_F488);
    chk_rd("R1 ctla", 2'd1, 32'h0);
    chk_rd("R1 ctlb", 2'd2, 32'h0);
    chk_rd("R1 rstc", 2'd3, 32'h0);
    chk("R1 irq", 32'(wdt_irq), 32'h0);
    chk("R1 rst_req", 32'(wdt_rst_req), 32'h0);

    // Table: keyed and unkeyed writes, readback (R2 R3 R4 R5 R11)
    for (int i = 0; i < 11; i++) begin
      string tag;
      case (VECS[i][65:64])
        2'd0:    tag = "R2/R11 count";
        2'd1:    tag = "R3/R11 ctla";
        2'd2:    tag = "R4/R11 ctlb";
        default: tag = "R5/R11 rstc";
      endcase
      wr(VECS[i][65:64], VECS[i][63:32]);
      chk_rd(tag, VECS[i][65:64], VECS[i][31:0]);
      step(600);
    end

    // R10 busy with divisor 1
    wr(2'd2, 32'hA5A5_A500);
    chk_rd("R10 ctlb write no busy", 2'd1, 32'h07);
    wr(2'd1, 32'hA5A5_A507);
    chk_rd("R10 busy set", 2'd1, 32'h27);
    step(1);
    chk_rd("R10 busy tick1", 2'd1, 32'h27);
    step(1);
    chk_rd("R10 busy clear", 2'd1, 32'h07);

    // R10/R6 busy with divide by 16
    wr(2'd1, 32'hA5A5_A502);
    chk_rd("R10 busy d16 set", 2'd1, 32'h22);
    step(31);
    chk_rd("R10 busy d16 cycle31", 2'd1, 32'h22);
    step(1);
    chk_rd("R10 busy d16 cycle32", 2'd1, 32'h02);
    wr(2'd1, 32'h5A5A_5A82);
    chk_rd("R10 wrong key no busy", 2'd1, 32'h02);
    wr(2'd3, 32'hA55A_0000);
    chk_rd("R10 rstc write no busy", 2'd1, 32'h02);
    chk_rd("R5 rstc cleared", 2'd3, 32'h0);
    wr(2'd1, 32'hA5A5_A507);
    step(4);

    // R7 counting and hold
    wr(2'd0, 32'h5A5A_0000);
    wr(2'd1, 32'hA5A5_A587);
    step(10);
    chk_rd("R7 ten ticks", 2'd0, 32'h0000_000A);
    wr(2'd1, 32'hA5A5_A507);
    chk_rd("R7 stop", 2'd0, 32'h0000_000A);
    step(20);
    chk_rd("R7 hold", 2'd0, 32'h0000_000A);

    // R8 R9 overflow unmasked
    wr(2'd0, 32'h5A5A_FFFD);
    wr(2'd1, 32'hA5A5_A58F);
    chk("R8 irq before wrap", 32'(wdt_irq), 32'h0);
    step(1);
    chk("R9 no req FFFE", 32'(wdt_rst_req), 32'h0);
    step(1);
    chk_rd("R7 at FFFF", 2'd0, 32'h0000_FFFF);
    chk("R9 no req FFFF", 32'(wdt_rst_req), 32'h0);
    step(1);
    chk("R9 req pulse", 32'(wdt_rst_req), 32'h1);
    chk("R8 irq set", 32'(wdt_irq), 32'h1);
    chk_rd("R8 wrap to zero", 2'd0, 32'h0);
    step(1);
    chk("R9 req one cycle", 32'(wdt_rst_req), 32'h0);
    chk("R8 irq holds", 32'(wdt_irq), 32'h1);
    chk_rd("R8 ovf flag read", 2'd1, 32'h9F);
    wr(2'd1, 32'hA5A5_A517);
    chk_rd("R3 write1 keeps ovf", 2'd1, 32'h37);
    chk("R8 irq off ie0", 32'(wdt_irq), 32'h0);
    wr(2'd1, 32'hA5A5_A507);
    chk_rd("R3 write0 clears ovf", 2'd1, 32'h27);
    wr(2'd1, 32'hA5A5_A517);
    chk_rd("R3 write1 no set", 2'd1, 32'h27);
    step(4);

    // R9 masked overflow, R8 ie gating
    wr(2'd3, 32'hA55A_0002);
    chk_rd("R5 mask stored", 2'd3, 32'h2);
    wr(2'd0, 32'h5A5A_FFFE);
    wr(2'd1, 32'hA5A5_A587);
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk("R9 masked no req", 32'(wdt_rst_req), 32'h0);
    end
    chk_rd("R8 ovf set ie0", 2'd1, 32'h97);
    chk("R8 irq gated", 32'(wdt_irq), 32'h0);
    wr(2'd1, 32'hA5A5_A59F);
    chk("R8 irq on enable", 32'(wdt_irq), 32'h1);
    wr(2'd1, 32'hA5A5_A507);
    step(4);

    // R6 divider selections
    wr(2'd0, 32'h5A5A_0000);
    wr(2'd1, 32'hA5A5_A582);
    step(15);
    chk_rd("R6 d16 before", 2'd0, 32'h0);
    step(1);
    chk_rd("R6 d16 first", 2'd0, 32'h1);
    step(16);
    chk_rd("R6 d16 second", 2'd0, 32'h2);
    wr(2'd1, 32'hA5A5_A502);
    wr(2'd2, 32'hA5A5_A505);
    wr(2'd0, 32'h5A5A_0000);
    wr(2'd1, 32'hA5A5_A587);
    step(5);
    chk_rd("R6 ext d6 before", 2'd0, 32'h0);
    step(1);
    chk_rd("R6 ext d6 first", 2'd0, 32'h1);
    wr(2'd1, 32'hA5A5_A507);
    wr(2'd0, 32'h5A5A_0000);
    wr(2'd1, 32'hA5A5_A580);
    step(3);
    chk_rd("R6 d4 before", 2'd0, 32'h0);
    step(1);
    chk_rd("R6 d4 first", 2'd0, 32'h1);
    wr(2'd0, 32'h5A5A_1000);
    chk_rd("R2 load while running", 2'd0, 32'h0000_1000);

    summary();
    $finish;
  end
endmodule